// File: doc/BRIEF.md
# USB Controller Interrupt Aggregator

This block sits beside a USB controller core and turns its scattered event pulses into a single level interrupt for a host CPU. Events come in two groups. The endpoint group carries one bit per transmit or receive endpoint. The core group carries a nine-bit field of controller-level events. Each group keeps a sticky source word and an enable word. Software reaches both words through a small 32-bit register port. The port offers a plain view of each word and write-one aliases that set or clear bits atomically, so no read-modify-write sequence is needed.

The output line rises when an enabled source is pending and the line is armed. Rising disarms the line. After that the line cannot rise again until software writes the end-of-interrupt register. A handler that leaves a source set therefore does not cause a storm of interrupts. A control bit clears every source and enable bit at once. A fixed revision word lets software confirm that the block is present and clocked. A status word reports the present level of the VBUS-drive signal.

Top module: `usb_irq_agg`

## Requirements
- R1: Offset 0x00 reads the nonzero parameter REVISION and ignores writes. Offset 0x08 reads the `vbus_drv` input in bit 0 and zero in every other bit.
- R2: In the endpoint word, bits 15:0 are transmit endpoints 0..15 and bits 31:17 are receive endpoints 1..15. Bit 16 of both the source word and the enable word always reads 0, whatever is written or signalled.
- R3: The core word holds its nine event bits at word bits 24:16, and all other bits read 0. Core event input bit 8, the VBUS-drive change event, appears at word bit 24.
- R4: A one-cycle pulse on an event input bit leaves the matching source bit set until software clears it.
- R5: Writing to source-set (endpoint 0x24, core 0x44) sets the source bits that are 1 in the data. Writing to source-clear (0x28, 0x48) clears them. Zero bits leave their source bits unchanged. If an event arrives in the same cycle as a clear of its bit, the bit stays set.
- R6: Writing to the enable word (0x2C, 0x4C) loads it. Enable-set (0x30, 0x50) ORs the data into it. Enable-clear (0x34, 0x54) clears the bits that are 1 in the data.
- R7: The masked view (0x38, 0x58) reads source AND enable. The source-set and source-clear aliases read back the source word. The enable-set and enable-clear aliases read back the enable word. Writes to the source view (0x20, 0x40) and to the masked view are ignored.
- R8: `irq` rises on the clock edge after the edge that makes a masked word nonzero, provided the line is armed. This holds for both groups. `irq` is 0 after reset.
- R9: Once `irq` has risen, it stays high while any masked bit is pending and falls on the edge after pending clears. It does not rise again until a write to 0x60 (any data). That write re-arms the line, and `irq` then rises on the following edge if an event is still pending.
- R10: Writing 1 to bit 0 of offset 0x04 clears every source and enable bit and re-arms the line. Writing 0 there has no effect. Offset 0x04 reads 0.
- R11: Any other offset, including 0x10, 0x5C, 0x1C, 0x3C and addresses that are not word aligned, reads 0 and ignores writes.
- R12: A read request is answered on the following cycle with `rd_valid` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| ep_evt | input | 32 | Endpoint event pulses, one bit per endpoint word bit |
| core_evt | input | 9 | Core event pulses, placed at word bits 24:16 |
| vbus_drv | input | 1 | Current VBUS-drive level, reported in status |
| irq | output | 1 | Level interrupt to the host |

## Verification
The assertions check, on every cycle, the following properties. Unused bit positions never hold state. A signalled event is recorded by the next edge unless a soft reset takes priority. The line never rises without a pending masked bit on the previous cycle. A disarmed, low line stays low until an end-of-interrupt or a soft reset. Every read is answered one cycle later. The bench scenarios show the rest: the exact edge on which the line rises and falls, the re-arm after an end-of-interrupt, and the event-beats-clear collision. They also show the read-back of every alias and the silence of reserved offsets. Each of these needs a specific sequence of accesses and events.

// File: rtl/usb_irq_agg_pkg.sv
package usb_irq_agg_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned NGRP   = 2;
  localparam int unsigned GIDX_W = (NGRP > 1) ? $clog2(NGRP) : 1;

  localparam int unsigned GRP_EP   = 0;
  localparam int unsigned GRP_CORE = 1;

  localparam logic [ADDR_W-1:0] OFF_REV  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_EOI  = 8'h60;

  // Highest sub-offset inside a group window (the masked view)
  localparam logic [ADDR_W-1:0] GRP_SPAN = 8'h18;

  localparam logic [DATA_W-1:0] EP_VALID   = 32'hFFFE_FFFF;
  localparam logic [DATA_W-1:0] CORE_VALID = 32'h01FF_0000;
  localparam int unsigned CORE_LSB = 16;
  localparam int unsigned CORE_W   = 9;

  // Register kind inside a group window, in sub-offset order
  typedef enum logic [2:0] {
    GR_RAW    = 3'd0,
    GR_SET    = 3'd1,
    GR_CLR    = 3'd2,
    GR_MASK   = 3'd3,
    GR_MSET   = 3'd4,
    GR_MCLR   = 3'd5,
    GR_MASKED = 3'd6,
    GR_NONE   = 3'd7
  } grp_reg_e;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_REV  = 2'd1,
    RD_STAT = 2'd2,
    RD_GRP  = 2'd3
  } rd_kind_e;

  typedef struct packed {
    logic src_set;
    logic src_clr;
    logic mask_wr;
    logic mask_set;
    logic mask_clr;
  } grp_wr_t;

  function automatic logic [ADDR_W-1:0] grp_base(input int unsigned g);
    return (g == GRP_EP) ? 8'h20 : 8'h40;
  endfunction

  function automatic logic [DATA_W-1:0] grp_valid(input int unsigned g);
    return (g == GRP_EP) ? EP_VALID : CORE_VALID;
  endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import usb_irq_agg_pkg::*;
(
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     ctrl_bit0,
  output grp_wr_t [NGRP-1:0]       grp_wr,
  output logic                     soft_clr,
  output logic                     eoi_hit,
  output logic                     rd_fire,
  output rd_kind_e                 rd_kind,
  output logic [GIDX_W-1:0]        rd_grp,
  output grp_reg_e                 rd_reg
);

  logic                    wr_fire;
  logic [ADDR_W-1:0]       off;
  logic                    hit;
  grp_reg_e                kind;

  assign wr_fire  = req_valid & req_write;
  assign rd_fire  = req_valid & ~req_write;
  assign soft_clr = wr_fire & (req_addr == OFF_CTRL) & ctrl_bit0;
  assign eoi_hit  = wr_fire & (req_addr == OFF_EOI);

  always_comb begin
    grp_wr  = '0;
    rd_kind = RD_ZERO;
    rd_grp  = '0;
    rd_reg  = GR_NONE;
    off     = '0;
    hit     = 1'b0;
    kind    = GR_NONE;
    if (req_addr == OFF_REV)  rd_kind = RD_REV;
    if (req_addr == OFF_STAT) rd_kind = RD_STAT;
    for (int g = 0; g < NGRP; g++) begin
      off = req_addr - grp_base(g);
      hit = (off <= GRP_SPAN) && (off[1:0] == 2'b00);
      if (hit) begin
        kind    = grp_reg_e'(off[4:2]);
        rd_kind = RD_GRP;
        rd_grp  = GIDX_W'(g);
        rd_reg  = kind;
        grp_wr[g].src_set  = wr_fire & (kind == GR_SET);
        grp_wr[g].src_clr  = wr_fire & (kind == GR_CLR);
        grp_wr[g].mask_wr  = wr_fire & (kind == GR_MASK);
        grp_wr[g].mask_set = wr_fire & (kind == GR_MSET);
        grp_wr[g].mask_clr = wr_fire & (kind == GR_MCLR);
      end
    end
  end

endmodule

// File: rtl/irq_src_group.sv
module irq_src_group
  import usb_irq_agg_pkg::*;
#(
  parameter logic [DATA_W-1:0] VALID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  grp_wr_t           wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] evt,
  output logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] masked
);

  logic [DATA_W-1:0] src_q, src_d, mask_q, mask_d;
  logic [DATA_W-1:0] set_v, clr_v, evt_v;
  logic              src_en, mask_en;

  assign evt_v = evt & VALID;
  assign set_v = wr.src_set ? wdata : '0;
  assign clr_v = wr.src_clr ? wdata : '0;

  // Source next state: events are ORed after the clear so they win
  always_comb begin
    src_en = soft_clr | wr.src_set | wr.src_clr | (|evt_v);
    if (soft_clr) src_d = '0;
    else          src_d = ((src_q & ~clr_v) | set_v | evt_v) & VALID;
  end

  always_comb begin
    mask_en = soft_clr | wr.mask_wr | wr.mask_set | wr.mask_clr;
    if (soft_clr)          mask_d = '0;
    else if (wr.mask_wr)   mask_d = wdata & VALID;
    else if (wr.mask_set)  mask_d = (mask_q | wdata) & VALID;
    else if (wr.mask_clr)  mask_d = mask_q & ~wdata;
    else                   mask_d = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= '0;
    else if (src_en) src_q <= src_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign src    = src_q;
  assign mask   = mask_q;
  assign masked = src_q & mask_q;

endmodule

// File: rtl/irq_eoi_gate.sv
module irq_eoi_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic eoi,
  input  logic pending,
  output logic armed,
  output logic irq
);

  logic armed_q, armed_d, line_q, line_d, gate_en;

  always_comb begin
    if (soft_clr | eoi)          armed_d = 1'b1;
    else if (armed_q & pending)  armed_d = 1'b0;
    else                         armed_d = armed_q;
    line_d  = ~soft_clr & pending & (line_q | armed_q);
    gate_en = soft_clr | eoi | pending | line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      line_q  <= 1'b0;
    end else if (gate_en) begin
      armed_q <= armed_d;
      line_q  <= line_d;
    end
  end

  assign armed = armed_q;
  assign irq   = line_q;

endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg
  import usb_irq_agg_pkg::*;
#(
  parameter logic [DATA_W-1:0] REVISION = 32'h0002_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] ep_evt,
  input  logic [CORE_W-1:0] core_evt,
  input  logic              vbus_drv,
  output logic              irq
);

  grp_wr_t [NGRP-1:0] grp_wr;
  logic               soft_clr, eoi_hit, rd_fire;
  rd_kind_e           rd_kind;
  logic [GIDX_W-1:0]  rd_grp;
  grp_reg_e           rd_reg;

  logic [DATA_W-1:0]  evt_w    [NGRP];
  logic [DATA_W-1:0]  src_w    [NGRP];
  logic [DATA_W-1:0]  mask_w   [NGRP];
  logic [DATA_W-1:0]  masked_w [NGRP];
  logic [NGRP-1:0]    grp_pend;
  logic               pending, gate_armed;

  logic [DATA_W-1:0]  ep_src, ep_mask, core_src, core_mask;
  logic [DATA_W-1:0]  rd_next, rd_q;
  logic               rd_valid_q;

  irq_reg_decode u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .ctrl_bit0 (req_wdata[0]),
    .grp_wr    (grp_wr),
    .soft_clr  (soft_clr),
    .eoi_hit   (eoi_hit),
    .rd_fire   (rd_fire),
    .rd_kind   (rd_kind),
    .rd_grp    (rd_grp),
    .rd_reg    (rd_reg)
  );

  assign evt_w[GRP_EP]   = ep_evt;
  assign evt_w[GRP_CORE] = DATA_W'(core_evt) << CORE_LSB;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    irq_src_group #(.VALID(grp_valid(g))) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .wr       (grp_wr[g]),
      .wdata    (req_wdata),
      .evt      (evt_w[g]),
      .src      (src_w[g]),
      .mask     (mask_w[g]),
      .masked   (masked_w[g])
    );
    assign grp_pend[g] = |masked_w[g];
  end

  assign pending   = |grp_pend;
  assign ep_src    = src_w[GRP_EP];
  assign ep_mask   = mask_w[GRP_EP];
  assign core_src  = src_w[GRP_CORE];
  assign core_mask = mask_w[GRP_CORE];

  irq_eoi_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .eoi      (eoi_hit),
    .pending  (pending),
    .armed    (gate_armed),
    .irq      (irq)
  );

  always_comb begin
    rd_next = '0;
    unique case (rd_kind)
      RD_REV:  rd_next = REVISION;
      RD_STAT: rd_next = DATA_W'(vbus_drv);
      RD_GRP: begin
        case (rd_reg)
          GR_RAW, GR_SET, GR_CLR:    rd_next = src_w[rd_grp];
          GR_MASK, GR_MSET, GR_MCLR: rd_next = mask_w[rd_grp];
          GR_MASKED:                 rd_next = masked_w[rd_grp];
          default:                   rd_next = '0;
        endcase
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_fire) rd_q <= rd_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= rd_fire;
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_q;

endmodule

// File: rtl/usb_irq_agg_chk.sv
module usb_irq_agg_chk
  import usb_irq_agg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              rd_valid,
  input logic              irq,
  input logic [DATA_W-1:0] ep_evt,
  input logic [DATA_W-1:0] ep_src,
  input logic [DATA_W-1:0] ep_mask,
  input logic [DATA_W-1:0] core_src,
  input logic [DATA_W-1:0] core_mask,
  input logic              soft_clr,
  input logic              eoi_hit,
  input logic              gate_armed
);

  logic              pend;
  logic [DATA_W-1:0] ep_hit;

  assign pend   = |(ep_src & ep_mask) | |(core_src & core_mask);
  assign ep_hit = ep_evt & EP_VALID;

  a_r2_bit16_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!ep_src[16] && !ep_mask[16]));

  a_r3_core_field_only: assert property (@(posedge clk) disable iff (!rst_n)
    (((core_src | core_mask) & ~CORE_VALID) == '0));

  a_r4_event_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && (ep_hit != '0)) |=> ((ep_src & $past(ep_hit)) == $past(ep_hit)));

  a_r8_line_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pend));

  a_r9_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_armed && !irq && !eoi_hit && !soft_clr) |=> !irq);

  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (ep_src == '0 && core_src == '0 && ep_mask == '0 &&
                  core_mask == '0 && !irq));

  a_r12_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  a_r12_no_spurious_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);

endmodule

bind usb_irq_agg usb_irq_agg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .rd_valid   (rd_valid),
  .irq        (irq),
  .ep_evt     (ep_evt),
  .ep_src     (ep_src),
  .ep_mask    (ep_mask),
  .core_src   (core_src),
  .core_mask  (core_mask),
  .soft_clr   (soft_clr),
  .eoi_hit    (eoi_hit),
  .gate_armed (gate_armed)
);

// File: tb/usb_irq_agg_tb.sv
module usb_irq_agg_tb;
  import usb_irq_agg_pkg::*;

  localparam logic [31:0] REV = 32'h0002_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [31:0] ep_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        vbus_drv = 1'b1;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  usb_irq_agg #(.REVISION(REV)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .ep_evt(ep_evt), .core_evt(core_evt),
    .vbus_drv(vbus_drv), .irq(irq)
  );

  // Monitor: pops the scoreboard whenever a read answer appears
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rd_valid) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R12 unexpected read answer: actual %h expected none", rd_data);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (rd_data !== e) begin
            n_fail++;
            $display("FAIL %s read: actual %h expected %h", t, rd_data, e);
          end
        end
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic ev_ep(input logic [31:0] v);
    @(negedge clk); ep_evt = v;
    @(negedge clk); ep_evt = '0;
  endtask

  task automatic ev_core(input logic [8:0] v);
    @(negedge clk); core_evt = v;
    @(negedge clk); core_evt = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq: actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 identity and status, R8 reset state
    chk_irq(1'b0, "R8 reset");
    rd(8'h00, REV, "R1 revision");
    rd(8'h08, 32'h1, "R1 status high");
    rd(8'h20, 32'h0, "R4 reset source");
    rd(8'h2C, 32'h0, "R6 reset mask");
    vbus_drv = 1'b0;
    rd(8'h08, 32'h0, "R1 status low");
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, REV, "R1 revision write ignored");

    // R2 R5 R7 endpoint set/clear aliases
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h20, 32'hFFFE_FFFF, "R2 bit16 stays zero");
    rd(8'h24, 32'hFFFE_FFFF, "R7 set alias reads source");
    rd(8'h28, 32'hFFFE_FFFF, "R7 clear alias reads source");
    wr(8'h28, 32'h0000_FFFF);
    rd(8'h20, 32'hFFFE_0000, "R5 partial clear");
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R5 full clear");

    // R4 event pulse, R2 bit 16 event dropped
    ev_ep(32'h0003_0001);
    rd(8'h20, 32'h0002_0001, "R4 event sticky");

    // R5 event wins over clear in same cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h28; req_wdata = 32'h1;
    ep_evt = 32'h1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; ep_evt = '0;
    rd(8'h20, 32'h0002_0001, "R5 event beats clear");

    // R7 raw and masked views ignore writes
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0002_0001, "R7 raw write ignored");

    // R6 enable word
    wr(8'h2C, 32'h0001_00F0);
    rd(8'h2C, 32'h0000_00F0, "R6 mask load, R2 bit16");
    wr(8'h30, 32'h1);
    wr(8'h34, 32'h10);
    rd(8'h30, 32'h0000_00E1, "R6 mask set/clear via alias");
    rd(8'h34, 32'h0000_00E1, "R7 mask clear alias");
    rd(8'h38, 32'h0000_0001, "R7 masked view");

    // R10 soft reset
    wr(8'h04, 32'h0);
    rd(8'h20, 32'h0002_0001, "R10 ctrl zero no effect");
    rd(8'h04, 32'h0, "R10 ctrl reads zero");
    wr(8'h04, 32'h1);
    rd(8'h20, 32'h0, "R10 source cleared");
    rd(8'h2C, 32'h0, "R10 mask cleared");
    chk_irq(1'b0, "R10 line low after soft reset");

    // R3 core field
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h40, 32'h01FF_0000, "R3 core field position");
    wr(8'h48, 32'hFFFF_FFFF);
    ev_core(9'h100);
    rd(8'h40, 32'h0100_0000, "R3 vbus-drive event bit 24");
    rd(8'h58, 32'h0, "R7 core masked with zero mask");
    wr(8'h48, 32'h0100_0000);

    // R8 R9 line and end-of-interrupt gating (armed by soft reset)
    wr(8'h50, 32'h0100_0000);
    ev_core(9'h100);
    chk_irq(1'b0, "R8 one-edge latency");
    @(negedge clk);
    chk_irq(1'b1, "R8 core line rises");
    wr(8'h48, 32'h0100_0000);
    chk_irq(1'b1, "R9 line holds until edge after clear");
    @(negedge clk);
    chk_irq(1'b0, "R9 line falls after clear");
    ev_core(9'h100);
    repeat (3) @(negedge clk);
    chk_irq(1'b0, "R9 no re-assert without EOI");
    rd(8'h58, 32'h0100_0000, "R7 core masked pending");
    wr(8'h60, 32'h0);
    chk_irq(1'b0, "R9 EOI latency");
    @(negedge clk);
    chk_irq(1'b1, "R9 EOI re-arms");
    wr(8'h48, 32'h0100_0000);
    wr(8'h60, 32'h0);
    @(negedge clk);
    chk_irq(1'b0, "R9 line idle after clear");

    // R8 endpoint group drives the line too
    wr(8'h30, 32'h0002_0000);
    wr(8'h24, 32'h0002_0000);
    chk_irq(1'b0, "R8 ep latency");
    @(negedge clk);
    chk_irq(1'b1, "R8 ep line rises");
    rd(8'h38, 32'h0002_0000, "R7 ep masked");
    wr(8'h28, 32'h0002_0000);
    wr(8'h60, 32'h0);
    @(negedge clk);
    chk_irq(1'b0, "R9 ep line cleared");

    // R11 unmapped offsets
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h5C, 32'hFFFF_FFFF);
    wr(8'h22, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0, "R11 offset 0x10");
    rd(8'h5C, 32'h0, "R11 offset 0x5C");
    rd(8'h1C, 32'h0, "R11 offset 0x1C");
    rd(8'h3C, 32'h0, "R11 offset 0x3C");
    rd(8'h22, 32'h0, "R11 unaligned");
    rd(8'h20, 32'h0, "R11 writes left source alone");
    rd(8'h4C, 32'h0100_0000, "R11 writes left core mask alone");
    chk_irq(1'b0, "R11 line untouched");

    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R12 unanswered reads: actual %0d expected 0", exp_q.size());
    end
    done = 1;
    finish_run();
  end

endmodule